// File: doc/BRIEF.md
# Stripmine Issue Expander

This block sits between a vector instruction command queue and the SIMD execution units. It takes one dispatched vector instruction at a time over a valid/ready handshake. When the instruction carries the stripmine flag, the block turns that one dispatch into four serialized issue events. On each event the vector register indices move on by one, so a group based on register 0 issues on registers 0, 1, 2 and 3 in turn.

Instructions without the flag issue exactly once. The issue side is a valid/ready interface that honours backpressure. Scalar operand fields and the opcode are passed through unchanged. Dependency checking and execution belong to neighbouring blocks.

Top module: `vstrip_expander`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `iss_valid_o` is 0 and `disp_ready_o` is 1.
- R2: A dispatch accepted in cycle n (`disp_valid_i` and `disp_ready_o` both 1) shows on the issue port in cycle n+1 with `iss_op_o`, `iss_vd_o`, `iss_vs1_o`, `iss_vs2_o` and `iss_xs_o` equal to the dispatched fields.
- R3: A dispatch with `disp_strip_i` = 1 produces exactly four issue events, one per issue handshake (`iss_valid_o` and `iss_ready_i` both 1), never merged.
- R4: On the k-th issue event of a stripmined group (k = 0..3), each vector index `iss_vd_o`, `iss_vs1_o`, `iss_vs2_o` equals its dispatched 6-bit value plus k, modulo 64 (base 62 gives 62, 63, 0, 1).
- R5: `iss_op_o` and `iss_xs_o` keep their dispatched values on every event of a group.
- R6: `iss_last_o` is 1 on the fourth event of a stripmined group and on the single event of an unmarked instruction, and 0 on the first three events of a stripmined group.
- R7: `disp_ready_o` is 0 while an issue event is pending that is not a last event being accepted in the same cycle; a dispatch offered during a group is not taken until the fourth event is accepted, and then follows it.
- R8: With `iss_ready_i` held at 1, unmarked instructions dispatched on consecutive cycles issue on consecutive cycles, one per cycle.
- R9: While `iss_valid_o` is 1 and `iss_ready_i` is 0, the issue port holds all its values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch instruction valid |
| disp_ready_o | output | 1 | Block can take a dispatch this cycle |
| disp_strip_i | input | 1 | Stripmine flag: expand to four events |
| disp_op_i | input | OP_W (8) | Opcode and type bits, passed through |
| disp_vd_i | input | 6 | Vector destination index |
| disp_vs1_i | input | 6 | First vector source index |
| disp_vs2_i | input | 6 | Second vector source index |
| disp_xs_i | input | XS_W (5) | Scalar operand index, passed through |
| iss_valid_o | output | 1 | Issue event valid |
| iss_ready_i | input | 1 | Execution unit accepts the event |
| iss_op_o | output | OP_W (8) | Issued opcode |
| iss_vd_o | output | 6 | Issued vector destination index |
| iss_vs1_o | output | 6 | Issued first vector source index |
| iss_vs2_o | output | 6 | Issued second vector source index |
| iss_xs_o | output | XS_W (5) | Issued scalar operand index |
| iss_last_o | output | 1 | Final event of the group |

## Verification
The bench drives bases of 62 and 63 so that a carry out of bit 5 must wrap to 0; a design that widened the index or saturated would issue on 64 or stick at 63. It holds `iss_ready_i` low mid-group while offering a second dispatch, which catches a design that steps the beat on a stalled cycle, lets the new dispatch jump in before the fourth event, or drops it. A stream of back-to-back unmarked instructions exposes a design that inserts a bubble after each single issue, or that flags the last event on the wrong beat.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int unsigned VREG_W = 6;
  localparam int unsigned NUM_VF = 3;
  typedef logic [VREG_W-1:0] vreg_t;
  typedef vreg_t [NUM_VF-1:0] vreg_vec_t;
endpackage

// File: rtl/sm_beat_ctr.sv
module sm_beat_ctr #(
  parameter int unsigned BEATS  = 4,
  localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              strip_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              final_o
);
  logic [BEAT_W-1:0] beat_q;

  assign final_o = !strip_i || (beat_q == BEAT_W'(BEATS - 1));
  assign beat_o  = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                beat_q <= '0;
    else if (start_i)           beat_q <= '0;
    else if (step_i && !final_o) beat_q <= beat_q + BEAT_W'(1);
  end
endmodule

// File: rtl/sm_vreg_step.sv
module sm_vreg_step #(
  parameter int unsigned BEAT_W = 2
) (
  input  sm_pkg::vreg_t     base_i,
  input  logic [BEAT_W-1:0] beat_i,
  output sm_pkg::vreg_t     idx_o
);
  // wraps modulo register count
  assign idx_o = base_i + sm_pkg::VREG_W'(beat_i);
endmodule

// File: rtl/sm_hold.sv
module sm_hold #(
  parameter int unsigned OP_W = 8,
  parameter int unsigned XS_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [OP_W-1:0]   op_i,
  input  sm_pkg::vreg_vec_t vr_i,
  input  logic [XS_W-1:0]   xs_i,
  input  logic              strip_i,
  output logic              busy_o,
  output logic [OP_W-1:0]   op_o,
  output sm_pkg::vreg_vec_t vr_o,
  output logic [XS_W-1:0]   xs_o,
  output logic              strip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      op_o    <= '0;
      vr_o    <= '0;
      xs_o    <= '0;
      strip_o <= 1'b0;
    end else if (load_i) begin
      busy_o  <= 1'b1;
      op_o    <= op_i;
      vr_o    <= vr_i;
      xs_o    <= xs_i;
      strip_o <= strip_i;
    end else if (clear_i) begin
      busy_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/vstrip_expander.sv
module vstrip_expander #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned XS_W  = 5,
  parameter int unsigned BEATS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      disp_valid_i,
  output logic                      disp_ready_o,
  input  logic                      disp_strip_i,
  input  logic [OP_W-1:0]           disp_op_i,
  input  logic [sm_pkg::VREG_W-1:0] disp_vd_i,
  input  logic [sm_pkg::VREG_W-1:0] disp_vs1_i,
  input  logic [sm_pkg::VREG_W-1:0] disp_vs2_i,
  input  logic [XS_W-1:0]           disp_xs_i,
  output logic                      iss_valid_o,
  input  logic                      iss_ready_i,
  output logic [OP_W-1:0]           iss_op_o,
  output logic [sm_pkg::VREG_W-1:0] iss_vd_o,
  output logic [sm_pkg::VREG_W-1:0] iss_vs1_o,
  output logic [sm_pkg::VREG_W-1:0] iss_vs2_o,
  output logic [XS_W-1:0]           iss_xs_o,
  output logic                      iss_last_o
);
  import sm_pkg::*;
  localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              busy, strip_q, final_beat, fire, load, clear;
  logic [BEAT_W-1:0] beat;
  vreg_vec_t         vr_in, vr_q, vr_out;

  assign vr_in = {disp_vs2_i, disp_vs1_i, disp_vd_i};

  assign fire         = iss_valid_o && iss_ready_i;
  assign clear        = fire && final_beat;
  // accept when empty, or when the final event leaves this cycle
  assign disp_ready_o = !busy || (iss_ready_i && final_beat);
  assign load         = disp_valid_i && disp_ready_o;

  sm_hold #(.OP_W(OP_W), .XS_W(XS_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .clear_i (clear),
    .op_i    (disp_op_i),
    .vr_i    (vr_in),
    .xs_i    (disp_xs_i),
    .strip_i (disp_strip_i),
    .busy_o  (busy),
    .op_o    (iss_op_o),
    .vr_o    (vr_q),
    .xs_o    (iss_xs_o),
    .strip_o (strip_q)
  );

  sm_beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (load),
    .step_i  (fire),
    .strip_i (strip_q),
    .beat_o  (beat),
    .final_o (final_beat)
  );

  for (genvar g = 0; g < NUM_VF; g++) begin : g_vf
    sm_vreg_step #(.BEAT_W(BEAT_W)) u_step (
      .base_i (vr_q[g]),
      .beat_i (beat),
      .idx_o  (vr_out[g])
    );
  end

  assign iss_valid_o = busy;
  assign iss_vd_o    = vr_out[0];
  assign iss_vs1_o   = vr_out[1];
  assign iss_vs2_o   = vr_out[2];
  assign iss_last_o  = busy && final_beat;
endmodule

// File: rtl/vstrip_expander_chk.sv
module vstrip_expander_chk #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned XS_W  = 5,
  parameter int unsigned BEATS = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      disp_valid_i,
  input logic                      disp_ready_o,
  input logic                      disp_strip_i,
  input logic [OP_W-1:0]           disp_op_i,
  input logic [sm_pkg::VREG_W-1:0] disp_vd_i,
  input logic [sm_pkg::VREG_W-1:0] disp_vs1_i,
  input logic [sm_pkg::VREG_W-1:0] disp_vs2_i,
  input logic [XS_W-1:0]           disp_xs_i,
  input logic                      iss_valid_o,
  input logic                      iss_ready_i,
  input logic [OP_W-1:0]           iss_op_o,
  input logic [sm_pkg::VREG_W-1:0] iss_vd_o,
  input logic [sm_pkg::VREG_W-1:0] iss_vs1_o,
  input logic [sm_pkg::VREG_W-1:0] iss_vs2_o,
  input logic [XS_W-1:0]           iss_xs_o,
  input logic                      iss_last_o
);
  localparam int unsigned W  = sm_pkg::VREG_W;
  localparam int unsigned CW = $clog2(BEATS + 1);

  logic          acc, fire;
  logic [CW-1:0] cnt_q;
  logic          grp_strip_q;

  assign acc  = disp_valid_i && disp_ready_o;
  assign fire = iss_valid_o && iss_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      grp_strip_q <= 1'b0;
    end else if (acc) begin
      cnt_q       <= '0;
      grp_strip_q <= disp_strip_i;
    end else if (fire) begin
      cnt_q       <= cnt_q + CW'(1);
    end
  end

  always_comb begin
    if (!rst_ni) assert_reset_idle_R1: assert (!iss_valid_o && disp_ready_o);
  end

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> iss_valid_o && iss_vd_o == $past(disp_vd_i) && iss_vs1_o == $past(disp_vs1_i)
            && iss_vs2_o == $past(disp_vs2_i) && iss_op_o == $past(disp_op_i)
            && iss_xs_o == $past(disp_xs_i));

  assert_four_beats_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && grp_strip_q |-> iss_last_o == (cnt_q == CW'(BEATS - 1)));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !iss_last_o |=> iss_valid_o && iss_vd_o == W'($past(iss_vd_o) + W'(1))
            && iss_vs1_o == W'($past(iss_vs1_o) + W'(1))
            && iss_vs2_o == W'($past(iss_vs2_o) + W'(1)));

  assert_scalar_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !iss_last_o |=> $stable(iss_op_o) && $stable(iss_xs_o));

  assert_single_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !grp_strip_q |-> iss_last_o);

  assert_no_early_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o && !(iss_ready_i && iss_last_o) |-> !disp_ready_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o && !iss_ready_i |=> iss_valid_o && $stable(iss_vd_o) && $stable(iss_vs1_o)
            && $stable(iss_vs2_o) && $stable(iss_op_o) && $stable(iss_xs_o)
            && $stable(iss_last_o));
endmodule

bind vstrip_expander vstrip_expander_chk #(.OP_W(OP_W), .XS_W(XS_W), .BEATS(BEATS)) u_chk (.*);

// File: tb/vstrip_expander_tb.sv
module vstrip_expander_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       disp_valid_i = 1'b0, disp_strip_i = 1'b0, iss_ready_i = 1'b0;
  logic [7:0] disp_op_i = '0;
  logic [5:0] disp_vd_i = '0, disp_vs1_i = '0, disp_vs2_i = '0;
  logic [4:0] disp_xs_i = '0;
  logic       disp_ready_o, iss_valid_o, iss_last_o;
  logic [7:0] iss_op_o;
  logic [5:0] iss_vd_o, iss_vs1_o, iss_vs2_o;
  logic [4:0] iss_xs_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  vstrip_expander u_dut (.*);

  // {strip, op[7:0], vd[5:0], vs1[5:0], vs2[5:0], xs[4:0]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 8'h21, 6'd0,  6'd8,  6'd16, 5'd3},
    {1'b0, 8'h05, 6'd10, 6'd11, 6'd12, 5'd7},
    {1'b1, 8'h33, 6'd62, 6'd63, 6'd61, 5'd31},
    {1'b1, 8'h44, 6'd60, 6'd1,  6'd2,  5'd0},
    {1'b0, 8'hff, 6'd63, 6'd0,  6'd63, 5'd15},
    {1'b1, 8'h10, 6'd5,  6'd5,  6'd5,  5'd9}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] e);
    disp_valid_i = 1'b1;
    disp_strip_i = e[31];
    disp_op_i    = e[30:23];
    disp_vd_i    = e[22:17];
    disp_vs1_i   = e[16:11];
    disp_vs2_i   = e[10:5];
    disp_xs_i    = e[4:0];
  endtask

  task automatic check_iss(input logic [31:0] e, input int k, input bit last);
    check(iss_valid_o == 1'b1, "R3 valid", int'(iss_valid_o), 1);
    check(iss_vd_o  == 6'(e[22:17] + k), "R4 vd",  int'(iss_vd_o),  int'(6'(e[22:17] + k)));
    check(iss_vs1_o == 6'(e[16:11] + k), "R4 vs1", int'(iss_vs1_o), int'(6'(e[16:11] + k)));
    check(iss_vs2_o == 6'(e[10:5] + k),  "R4 vs2", int'(iss_vs2_o), int'(6'(e[10:5] + k)));
    check(iss_op_o == e[30:23], "R5 op", int'(iss_op_o), int'(e[30:23]));
    check(iss_xs_o == e[4:0],   "R5 xs", int'(iss_xs_o), int'(e[4:0]));
    check(iss_last_o == last,   "R6 last", int'(iss_last_o), int'(last));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x, y;
    repeat (3) @(negedge clk_i);
    #1;
    check(iss_valid_o == 1'b0, "R1 valid in reset", int'(iss_valid_o), 0);
    check(disp_ready_o == 1'b1, "R1 ready in reset", int'(disp_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check(iss_valid_o == 1'b0, "R1 valid after reset", int'(iss_valid_o), 0);
    check(disp_ready_o == 1'b1, "R1 ready after reset", int'(disp_ready_o), 1);

    // table walk, downstream always ready (R2 R3 R4 R5 R6 R7)
    iss_ready_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      int n;
      n = VEC[i][31] ? 4 : 1;
      @(negedge clk_i);
      drive(VEC[i]);
      #1;
      check(disp_ready_o == 1'b1, "R7 idle ready", int'(disp_ready_o), 1);
      @(negedge clk_i);
      disp_valid_i = 1'b0;
      for (int k = 0; k < n; k++) begin
        #1;
        check_iss(VEC[i], k, k == n - 1);
        check(disp_ready_o == (k == n - 1), "R7 ready in group", int'(disp_ready_o), int'(k == n - 1));
        @(negedge clk_i);
      end
      #1;
      check(iss_valid_o == 1'b0, "R3 no fifth event", int'(iss_valid_o), 0);
    end

    // backpressure mid-group with a dispatch waiting (R9 R7)
    x = {1'b1, 8'h7a, 6'd20, 6'd30, 6'd40, 5'd2};
    y = {1'b0, 8'h3c, 6'd50, 6'd51, 6'd52, 5'd4};
    @(negedge clk_i);
    iss_ready_i = 1'b0;
    drive(x);
    @(negedge clk_i);
    drive(y);
    for (int c = 0; c < 3; c++) begin
      #1;
      check_iss(x, 0, 1'b0);
      check(disp_ready_o == 1'b0, "R7 stalled ready", int'(disp_ready_o), 0);
      @(negedge clk_i);
    end
    iss_ready_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      check_iss(x, k, k == 3);
      check(disp_ready_o == (k == 3), "R7 waiting dispatch", int'(disp_ready_o), int'(k == 3));
      @(negedge clk_i);
    end
    disp_valid_i = 1'b0;
    #1;
    check_iss(y, 0, 1'b1);
    @(negedge clk_i);
    #1;
    check(iss_valid_o == 1'b0, "R2 single issue of waiting", int'(iss_valid_o), 0);

    // stall on a single issue, then release (R9)
    @(negedge clk_i);
    iss_ready_i = 1'b0;
    drive(y);
    @(negedge clk_i);
    disp_valid_i = 1'b0;
    repeat (2) begin
      #1;
      check_iss(y, 0, 1'b1);
      check(iss_valid_o == 1'b1, "R9 held", int'(iss_valid_o), 1);
      @(negedge clk_i);
    end
    iss_ready_i = 1'b1;
    @(negedge clk_i);
    #1;
    check(iss_valid_o == 1'b0, "R9 released", int'(iss_valid_o), 0);

    // back-to-back unmarked stream (R8)
    @(negedge clk_i);
    drive({1'b0, 8'h90, 6'd30, 6'd0, 6'd1, 5'd1});
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk_i);
      if (i < 4) drive({1'b0, 8'(8'h90 + i), 6'(30 + i), 6'(i), 6'(i + 1), 5'(i + 1)});
      else disp_valid_i = 1'b0;
      #1;
      check_iss({1'b0, 8'(8'h90 + i - 1), 6'(30 + i - 1), 6'(i - 1), 6'(i), 5'(i)}, 0, 1'b1);
      check(disp_ready_o == 1'b1, "R8 ready every cycle", int'(disp_ready_o), 1);
    end
    @(negedge clk_i);
    #1;
    check(iss_valid_o == 1'b0, "R8 stream drained", int'(iss_valid_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule